// File: doc/BRIEF.md
# Eight-Point Row Inverse DCT

This block performs the first, horizontal pass of an 8x8 two-dimensional inverse discrete cosine transform. It takes one row of eight signed 16-bit coefficients and returns eight signed 16-bit intermediate samples, which a separate column pass consumes. The arithmetic uses seven cosine weights scaled by 2^14 and an even/odd butterfly. A rounding offset of 1024 is added to the even half, and every result is shifted right by 11. When every coefficient except the first is zero, the block does not use the weighted path and returns the first coefficient multiplied by eight.

Rows enter through a valid/ready handshake. The block is a two-stage pipeline. A row accepted on one rising edge appears on the output two rising edges later, flagged by a single-cycle valid pulse. A new row can be accepted on every cycle.

Top module: `row_idct8`

## Requirements
- R1: While rst_n is low, out_valid and in_ready are low and out_res is zero. in_ready is high from the first rising edge after rst_n goes high.
- R2: A row is accepted on a rising edge where in_valid and in_ready are both high. out_valid is high after exactly the second rising edge following acceptance, and it is high at no other time. Back-to-back rows give back-to-back results.
- R3: Coefficient k sits at in_coef[16k+15:16k]. The weights are 22725, 21407, 19266, 16383, 12873, 8867 and 4520 for indices 1 to 7. The even terms are e0=16383(x0+x4)+21407x2+8867x6+1024, e1=16383(x0-x4)+8867x2-21407x6+1024, e2=16383(x0-x4)-8867x2+21407x6+1024 and e3=16383(x0+x4)-21407x2-8867x6+1024.
- R4: When x1 to x7 are all zero, each of the eight results equals the low 16 bits of 8*x0. This applies even where the weighted formula would give a different value, for example x0=2000 gives 16000.
- R5: Each result is the low 16 bits of the exact integer sum arithmetically shifted right by 11. Full-scale inputs wrap and do not saturate.
- R6: The offset of 1024 is included before the shift. With only x2=-1, results 0 and 7 are -10 and not -11.
- R7: The odd terms are o0=22725x1+19266x3+12873x5+4520x7, o1=19266x1-4520x3-22725x5-12873x7, o2=12873x1-22725x3+4520x5+19266x7 and o3=4520x1-12873x3+19266x5-22725x7. Result k (at out_res[16k+15:16k]) is e_k+o_k for k<4 and e_(7-k)-o_(7-k) for k>=4.
- R8: While out_valid is low, out_res holds the last delivered result.
- R9: A cycle with in_valid low produces no output pulse two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A coefficient row is present |
| in_ready | output | 1 | The block can take a row |
| in_coef | input | 128 | Eight signed coefficients, index k at bits 16k+15:16k |
| out_valid | output | 1 | Single-cycle pulse marking a new result row |
| out_res | output | 128 | Eight signed results, index k at bits 16k+15:16k |

## Verification
A fault in the stage-one registers reaches the ports two edges after the affected row is accepted. A wrong even or odd term appears as mirrored errors: a fault in the even term for index k shows up in both result k and result 7-k, while a wrong odd term shifts those two results in opposite directions. A stuck or stale valid bit shows up immediately, as a missing or extra pulse against the expected two-cycle schedule. The bench therefore compares the valid flag and the held data on every clock. It uses rows chosen so that the shortcut, the rounding offset and the wrap each change at least one lane.

// File: rtl/row_idct8.sv
module row_idct8 #(
  parameter int CW    = 16,
  parameter int SHIFT = 11,
  parameter int ACC   = 34
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [8*CW-1:0]    in_coef,
  output logic               out_valid,
  output logic [8*CW-1:0]    out_res
);
  localparam int N     = 8;
  localparam int K1    = 22725;
  localparam int K2    = 21407;
  localparam int K3    = 19266;
  localparam int K4    = 16383;
  localparam int K5    = 12873;
  localparam int K6    = 8867;
  localparam int K7    = 4520;
  localparam int RBIAS = 1 << (SHIFT - 1);

  function automatic logic signed [ACC-1:0] mul(input int w, input logic signed [CW-1:0] v);
    logic signed [ACC-1:0] ev;
    logic signed [ACC-1:0] ew;
    ev = ACC'(v);
    ew = ACC'(w);
    return ev * ew;
  endfunction

  logic signed [CW-1:0] x [N];
  for (genvar k = 0; k < N; k++) begin : g_unpack
    assign x[k] = in_coef[k*CW +: CW];
  end

  wire take   = in_valid && in_ready;
  wire dc_row = (in_coef[N*CW-1:CW] == '0);

  logic signed [ACC-1:0] ev_c [4];
  logic signed [ACC-1:0] od_c [4];

  always_comb begin
    logic signed [ACC-1:0] base, p4;
    base = mul(K4, x[0]) + ACC'(RBIAS);
    p4   = mul(K4, x[4]);
    ev_c[0] = base + p4 + mul(K2, x[2]) + mul(K6, x[6]);
    ev_c[1] = base - p4 + mul(K6, x[2]) - mul(K2, x[6]);
    ev_c[2] = base - p4 - mul(K6, x[2]) + mul(K2, x[6]);
    ev_c[3] = base + p4 - mul(K2, x[2]) - mul(K6, x[6]);
    od_c[0] = mul(K1, x[1]) + mul(K3, x[3]) + mul(K5, x[5]) + mul(K7, x[7]);
    od_c[1] = mul(K3, x[1]) - mul(K7, x[3]) - mul(K1, x[5]) - mul(K5, x[7]);
    od_c[2] = mul(K5, x[1]) - mul(K1, x[3]) + mul(K7, x[5]) + mul(K3, x[7]);
    od_c[3] = mul(K7, x[1]) - mul(K5, x[3]) + mul(K3, x[5]) - mul(K1, x[7]);
  end

  logic                  s1_v;
  logic                  s1_dc;
  logic [CW-1:0]         s1_dcval;
  logic signed [ACC-1:0] ev_q [4];
  logic signed [ACC-1:0] od_q [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      s1_v     <= 1'b0;
      s1_dc    <= 1'b0;
      s1_dcval <= '0;
      for (int i = 0; i < 4; i++) begin
        ev_q[i] <= '0;
        od_q[i] <= '0;
      end
    end else begin
      in_ready <= 1'b1;
      s1_v     <= take;
      if (take) begin
        s1_dc    <= dc_row;
        s1_dcval <= {x[0][CW-4:0], 3'b000};
        for (int i = 0; i < 4; i++) begin
          ev_q[i] <= dc_row ? '0 : ev_c[i];
          od_q[i] <= dc_row ? '0 : od_c[i];
        end
      end
    end
  end

  logic [N*CW-1:0] lanes;
  for (genvar k = 0; k < 4; k++) begin : g_fold
    assign lanes[k*CW +: CW]       = s1_dc ? s1_dcval : CW'((ev_q[k] + od_q[k]) >>> SHIFT);
    assign lanes[(7-k)*CW +: CW]   = s1_dc ? s1_dcval : CW'((ev_q[k] - od_q[k]) >>> SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) out_res <= lanes;
    end
  end
endmodule

module row_idct8_chk #(
  parameter int CW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [8*CW-1:0] in_coef,
  input logic            out_valid,
  input logic [8*CW-1:0] out_res
);
  a_r2_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready, 2));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_res));

  a_r4_dc_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_coef[8*CW-1:CW] == '0) |=> ##1
      (out_res == {8{$past(in_coef[CW-4:0], 2), 3'b000}}));

  a_r1_reset_quiet: assert property (@(posedge clk)
    !$past(rst_n) |-> (!out_valid && !in_ready));
endmodule

bind row_idct8 row_idct8_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_coef(in_coef), .out_valid(out_valid), .out_res(out_res));

// File: tb/row_idct8_tb_top.sv
`timescale 1ns/1ps
module row_idct8_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_coef = '0;
  logic         out_valid;
  logic [127:0] out_res;

  int compared = 0;
  int mismatched = 0;
  logic [127:0] exp_q [$];
  string        tag_q [$];
  logic [1:0]   vpipe = 2'b00;
  logic [127:0] last_out = '0;

  always #4 clk = ~clk;

  row_idct8 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .out_valid(out_valid), .out_res(out_res));

  function automatic logic [127:0] ref_row(input logic [127:0] c);
    longint x [8];
    longint e [4];
    longint o [4];
    longint y;
    logic [127:0] r;
    for (int i = 0; i < 8; i++) x[i] = longint'($signed(c[i*16 +: 16]));
    if (c[127:16] == '0) begin
      for (int k = 0; k < 8; k++) r[k*16 +: 16] = 16'(x[0] * 8);
      return r;
    end
    e[0] = 16383*(x[0]+x[4]) + 21407*x[2] + 8867*x[6] + 1024;
    e[1] = 16383*(x[0]-x[4]) + 8867*x[2] - 21407*x[6] + 1024;
    e[2] = 16383*(x[0]-x[4]) - 8867*x[2] + 21407*x[6] + 1024;
    e[3] = 16383*(x[0]+x[4]) - 21407*x[2] - 8867*x[6] + 1024;
    o[0] = 22725*x[1] + 19266*x[3] + 12873*x[5] + 4520*x[7];
    o[1] = 19266*x[1] - 4520*x[3] - 22725*x[5] - 12873*x[7];
    o[2] = 12873*x[1] - 22725*x[3] + 4520*x[5] + 19266*x[7];
    o[3] = 4520*x[1] - 12873*x[3] + 19266*x[5] - 22725*x[7];
    for (int k = 0; k < 4; k++) begin
      y = (e[k] + o[k]) >>> 11;
      r[k*16 +: 16] = 16'(y);
      y = (e[k] - o[k]) >>> 11;
      r[(7-k)*16 +: 16] = 16'(y);
    end
    return r;
  endfunction

  function automatic logic [127:0] mk(input logic [15:0] a0, a1, a2, a3, a4, a5, a6, a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [127:0] row, input string tag);
    bit acc;
    @(negedge clk);
    check(out_valid === vpipe[1], "R2/R9 valid", 128'(out_valid), 128'(vpipe[1]));
    if (vpipe[1]) begin
      logic [127:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(out_res === e, t, out_res, e);
      last_out = out_res;
    end else begin
      check(out_res === last_out, "R8 hold", out_res, last_out);
    end
    in_valid = v;
    in_coef  = row;
    acc = v && (in_ready === 1'b1);
    if (acc) begin
      exp_q.push_back(ref_row(row));
      tag_q.push_back(tag);
    end
    vpipe = {vpipe[0], acc};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    in_valid = 1'b1;
    in_coef  = mk(16'd5, 16'd1, 0, 0, 0, 0, 0, 0);
    repeat (3) begin
      @(negedge clk);
      check(out_valid === 1'b0 && in_ready === 1'b0, "R1 reset quiet", {126'b0, out_valid, in_ready}, '0);
      check(out_res === '0, "R1 reset data", out_res, '0);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1 ready after reset", 128'(in_ready), 128'(1));

    step(1, mk(0, 0, 0, 0, 0, 0, 0, 0), "R4 zero row");
    step(1, mk(16'd2000, 0, 0, 0, 0, 0, 0, 0), "R4 dc 2000");
    step(1, mk(16'hFFFF, 0, 0, 0, 0, 0, 0, 0), "R4 dc -1");
    step(1, mk(16'h8000, 0, 0, 0, 0, 0, 0, 0), "R4 dc wrap");
    step(0, '0, "idle");
    step(1, mk(0, 0, 16'hFFFF, 0, 0, 0, 0, 0), "R6 bias x2=-1");
    step(0, '0, "idle");
    step(0, '0, "idle");
    step(1, mk(0, 16'd100, 0, 0, 0, 0, 0, 0), "R7 odd order x1");
    step(1, mk(0, 0, 0, 0, 0, 0, 0, 16'd300), "R7 odd order x7");
    step(1, mk(16'd2000, 16'd1, 0, 0, 0, 0, 0, 0), "R3 near dc");
    step(1, {8{16'h7FFF}}, "R5 wrap max");
    step(1, {8{16'h8000}}, "R5 wrap min");
    step(1, mk(16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000), "R5 wrap alt");
    step(1, mk(16'd123, 16'hFF00, 16'd77, 16'd5, 0, 0, 0, 0), "R3 upper half zero");
    for (int i = 0; i < 120; i++) begin
      logic [127:0] r;
      bit v;
      for (int k = 0; k < 8; k++) r[k*16 +: 16] = 16'($urandom);
      if (i % 3 == 0) r[127:64] = '0;
      if (i % 17 == 0) r[127:16] = '0;
      v = ($urandom % 4) != 0;
      step(v, r, "R3 random");
    end
    repeat (4) step(0, '0, "R9 drain");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule